// File: doc/BRIEF.md
# Power-Guided Memory Channel Scheduler

This block sits at the head of a memory channel whose chips receive link power only when a controller steers it to them. It takes cache-line read and write requests, each naming a chip, a bank within that chip and a tag. Each request moves one whole 512-bit line, and every bank lives entirely on one chip. A one-entry slot per bank holds pending work. A round-robin arbiter picks the next bank. A sequencer then steers a one-hot guide-select vector to the target chip, waits for it to settle, and issues an activate followed by a read or write command on a single command lane. For a write, the line is sent in the same cycle as the write command.

For a read, the guide stays on the chip from before the read command until the data returns. The return arrives a fixed number of cycles after the command, so the controller alone decides when the bus is used and banks never contend for it. Only one transaction is in flight at a time, which makes returns strictly in order. Activate spacing and a four-activate rolling window are enforced before each activate. When no work is pending, the guide goes dark.

Top module: `pgc_sched`

## Requirements
- R1: After reset the guide select is all zero, no command or response is valid, and a request to any bank is ready.
- R2: A request is accepted only when the slot of its bank is empty; while that bank has a pending request, req_ready is low for it and the stimulus adds no transaction.
- R3: Pending banks are served in round-robin order over the flat index {chip, bank}, starting just after the last bank served.
- R4: The guide select is one-hot or zero, and it names the chip of the current transaction on every command cycle. It returns to zero once the sequencer is idle with nothing pending.
- R5: The guide is held unchanged for at least SETTLE cycles before any command. When the chip changes, the activate comes SETTLE+1 cycles after the pick. When the guide already points at the chip, the activate comes in the cycle after the pick, subject to R6 and R7.
- R6: Two activates are at least T_RRD cycles apart.
- R7: The fifth activate comes no sooner than T_FAW cycles after the first of the four before it.
- R8: Command codes are 1 = activate, 2 = read and 3 = write. A write command follows its activate in the next cycle, with wr_valid high and wr_data equal to the request's line.
- R9: rsp_valid rises exactly RD_LAT cycles after a read command, carrying the request tag and mem_rdata, while the guide still selects that chip.
- R10: Responses appear in request-service order, and no command is issued while a response is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Slot of the addressed bank is free |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_chip | input | $clog2(NUM_CHIPS) | Target chip |
| req_bank | input | $clog2(BANKS_PER_CHIP) | Bank within chip |
| req_tag | input | TAG_W | Request tag |
| req_wdata | input | LINE_W | Write line |
| cmd_valid | output | 1 | Command lane valid |
| cmd_op | output | 2 | 1 activate, 2 read, 3 write |
| cmd_chip | output | $clog2(NUM_CHIPS) | Command chip |
| cmd_bank | output | $clog2(BANKS_PER_CHIP) | Command bank |
| wr_valid | output | 1 | Write line beat |
| wr_data | output | LINE_W | Write line |
| guide_sel | output | NUM_CHIPS | One-hot power guide select |
| mem_rdata | input | LINE_W | Line returned by the selected chip |
| rsp_valid | output | 1 | Read response |
| rsp_tag | output | TAG_W | Tag of the response |
| rsp_data | output | LINE_W | Returned line |

## Verification
A request offered in the cycle the bench samples as k is picked in cycle k+1. If the guide must move, the activate falls at k+2+SETTLE, and the read or write command follows one cycle later. A response is due RD_LAT cycles after the read command. The activates that follow are due at the later of the previous activate plus T_RRD and the fourth-previous activate plus T_FAW. The bench logs the cycle number of every command and response on the falling edge. It then compares these cycle numbers with values computed from the parameters, so every check lands exactly in the cycle a result is due.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ACT  = 2'd1,
        OP_RD   = 2'd2,
        OP_WR   = 2'd3
    } cmd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_ACT,
        ST_RW,
        ST_RWAIT
    } seq_st_e;

    localparam int ACT_WINDOW = 4;
endpackage

// File: rtl/pgc_rr_arb.sv
module pgc_rr_arb #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [IW-1:0] gnt,
    output logic          any
);
    // N is a power of two, so pointer arithmetic wraps naturally.
    logic [IW-1:0] ptr_d, ptr_q;

    always_comb begin
        logic [IW-1:0] idx;
        any = 1'b0;
        gnt = '0;
        for (int i = 0; i < N; i++) begin
            idx = ptr_q + IW'(i);
            if (!any && req[idx]) begin
                any = 1'b1;
                gnt = idx;
            end
        end
        ptr_d = adv ? gnt + IW'(1) : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/pgc_act_timer.sv
module pgc_act_timer import pgc_pkg::*; #(
    parameter int T_RRD = 3,
    parameter int T_FAW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic ok
);
    localparam int LIM = (T_FAW > T_RRD) ? T_FAW : T_RRD;
    localparam int TW  = $clog2(LIM + 1);

    typedef struct packed {
        logic [TW-1:0]                  rrd;
        logic [ACT_WINDOW-1:0][TW-1:0]  age;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (act) begin
            t_d.rrd    = TW'(1);
            t_d.age[0] = TW'(1);
            for (int i = 1; i < ACT_WINDOW; i++)
                t_d.age[i] = (t_q.age[i-1] >= TW'(T_FAW)) ? TW'(T_FAW) : t_q.age[i-1] + TW'(1);
        end else begin
            if (t_q.rrd < TW'(T_RRD)) t_d.rrd = t_q.rrd + TW'(1);
            for (int i = 0; i < ACT_WINDOW; i++)
                if (t_q.age[i] < TW'(T_FAW)) t_d.age[i] = t_q.age[i] + TW'(1);
        end
        ok = (t_q.rrd >= TW'(T_RRD)) && (t_q.age[ACT_WINDOW-1] >= TW'(T_FAW));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.rrd <= TW'(T_RRD);
            for (int i = 0; i < ACT_WINDOW; i++) t_q.age[i] <= TW'(T_FAW);
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/pgc_sched.sv
module pgc_sched import pgc_pkg::*; #(
    parameter int NUM_CHIPS      = 2,
    parameter int BANKS_PER_CHIP = 4,
    parameter int TAG_W          = 4,
    parameter int LINE_W         = 512,
    parameter int T_RRD          = 3,
    parameter int T_FAW          = 16,
    parameter int RD_LAT         = 4,
    parameter int SETTLE         = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic                              req_write,
    input  logic [$clog2(NUM_CHIPS)-1:0]      req_chip,
    input  logic [$clog2(BANKS_PER_CHIP)-1:0] req_bank,
    input  logic [TAG_W-1:0]                  req_tag,
    input  logic [LINE_W-1:0]                 req_wdata,
    output logic                              cmd_valid,
    output logic [1:0]                        cmd_op,
    output logic [$clog2(NUM_CHIPS)-1:0]      cmd_chip,
    output logic [$clog2(BANKS_PER_CHIP)-1:0] cmd_bank,
    output logic                              wr_valid,
    output logic [LINE_W-1:0]                 wr_data,
    output logic [NUM_CHIPS-1:0]              guide_sel,
    input  logic [LINE_W-1:0]                 mem_rdata,
    output logic                              rsp_valid,
    output logic [TAG_W-1:0]                  rsp_tag,
    output logic [LINE_W-1:0]                 rsp_data
);
    localparam int CHW  = $clog2(NUM_CHIPS);
    localparam int BW   = $clog2(BANKS_PER_CHIP);
    localparam int NB   = NUM_CHIPS * BANKS_PER_CHIP;
    localparam int FW   = CHW + BW;
    localparam int CMAX = (SETTLE > RD_LAT) ? SETTLE : RD_LAT;
    localparam int CNTW = $clog2(CMAX + 1);

    typedef struct packed {
        seq_st_e                       st;
        logic [NUM_CHIPS-1:0]          guide;
        logic [CNTW-1:0]               cnt;
        logic [FW-1:0]                 cur;
        logic                          cur_wr;
        logic [TAG_W-1:0]              cur_tag;
        logic [LINE_W-1:0]             cur_data;
        logic [NB-1:0]                 sv;
        logic [NB-1:0]                 sw;
        logic [NB-1:0][TAG_W-1:0]      stag;
        logic [NB-1:0][LINE_W-1:0]     sdata;
    } sched_t;

    sched_t s_d, s_q;

    logic          arb_any, arb_adv, t_ok, act_fire;
    logic [FW-1:0] arb_gnt, req_idx;
    logic [NUM_CHIPS-1:0] tgt;

    pgc_rr_arb #(.N(NB)) u_arb (
        .clk (clk), .rst_n(rst_n), .req(s_q.sv), .adv(arb_adv),
        .gnt (arb_gnt), .any(arb_any)
    );

    pgc_act_timer #(.T_RRD(T_RRD), .T_FAW(T_FAW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .act(act_fire), .ok(t_ok)
    );

    assign act_fire = (s_q.st == ST_ACT) && t_ok;

    always_comb begin
        s_d     = s_q;
        arb_adv = 1'b0;
        tgt     = '0;
        req_idx = {req_chip, req_bank};
        req_ready = !s_q.sv[req_idx];

        // slot fill: a full slot never accepts, so it cannot clash with the pick below
        if (req_valid && req_ready) begin
            s_d.sv[req_idx]    = 1'b1;
            s_d.sw[req_idx]    = req_write;
            s_d.stag[req_idx]  = req_tag;
            s_d.sdata[req_idx] = req_wdata;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (arb_any) begin
                    arb_adv          = 1'b1;
                    s_d.cur          = arb_gnt;
                    s_d.cur_wr       = s_q.sw[arb_gnt];
                    s_d.cur_tag      = s_q.stag[arb_gnt];
                    s_d.cur_data     = s_q.sdata[arb_gnt];
                    s_d.sv[arb_gnt]  = 1'b0;
                    tgt[arb_gnt[FW-1:BW]] = 1'b1;
                    if (s_q.guide == tgt) begin
                        s_d.st = ST_ACT;
                    end else begin
                        s_d.guide = tgt;
                        s_d.cnt   = '0;
                        s_d.st    = ST_SETTLE;
                    end
                end else begin
                    s_d.guide = '0;
                end
            end
            ST_SETTLE: begin
                if (s_q.cnt == CNTW'(SETTLE - 1)) s_d.st = ST_ACT;
                else                              s_d.cnt = s_q.cnt + CNTW'(1);
            end
            ST_ACT: begin
                if (t_ok) s_d.st = ST_RW;
            end
            ST_RW: begin
                if (s_q.cur_wr) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.st  = ST_RWAIT;
                    s_d.cnt = CNTW'(1);
                end
            end
            ST_RWAIT: begin
                if (s_q.cnt == CNTW'(RD_LAT)) s_d.st = ST_IDLE;
                else                          s_d.cnt = s_q.cnt + CNTW'(1);
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        cmd_valid = act_fire || (s_q.st == ST_RW);
        if (act_fire)               cmd_op = 2'(OP_ACT);
        else if (s_q.st == ST_RW)   cmd_op = s_q.cur_wr ? 2'(OP_WR) : 2'(OP_RD);
        else                        cmd_op = 2'(OP_NONE);
    end

    assign cmd_chip  = s_q.cur[FW-1:BW];
    assign cmd_bank  = s_q.cur[BW-1:0];
    assign wr_valid  = (s_q.st == ST_RW) && s_q.cur_wr;
    assign wr_data   = s_q.cur_data;
    assign guide_sel = s_q.guide;
    assign rsp_valid = (s_q.st == ST_RWAIT) && (s_q.cnt == CNTW'(RD_LAT));
    assign rsp_tag   = s_q.cur_tag;
    assign rsp_data  = mem_rdata;
endmodule

// File: rtl/pgc_sched_chk.sv
module pgc_sched_chk import pgc_pkg::*; #(
    parameter int NUM_CHIPS = 2,
    parameter int T_RRD     = 3,
    parameter int T_FAW     = 16,
    parameter int SETTLE    = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cmd_valid,
    input logic [1:0]                   cmd_op,
    input logic [$clog2(NUM_CHIPS)-1:0] cmd_chip,
    input logic [NUM_CHIPS-1:0]         guide_sel,
    input logic                         wr_valid,
    input logic                         rsp_valid
);
    localparam int LIM = (T_FAW > T_RRD) ? ((T_FAW > SETTLE) ? T_FAW : SETTLE)
                                         : ((T_RRD > SETTLE) ? T_RRD : SETTLE);
    localparam int TW = $clog2(LIM + 1);

    logic [NUM_CHIPS-1:0]          g_prev, want;
    logic [TW-1:0]                 stab, since;
    logic [ACT_WINDOW-1:0][TW-1:0] hist;
    logic                          is_act;

    assign is_act = cmd_valid && (cmd_op == 2'(OP_ACT));

    always_comb begin
        want = '0;
        want[cmd_chip] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_prev <= '0;
            stab   <= '0;
            since  <= TW'(T_RRD);
            for (int i = 0; i < ACT_WINDOW; i++) hist[i] <= TW'(T_FAW);
        end else begin
            g_prev <= guide_sel;
            if (guide_sel != g_prev)       stab <= '0;
            else if (stab < TW'(SETTLE))   stab <= stab + TW'(1);
            if (is_act)                    since <= TW'(1);
            else if (since < TW'(T_RRD))   since <= since + TW'(1);
            for (int i = 0; i < ACT_WINDOW; i++) begin
                if (is_act)
                    hist[i] <= (i == 0) ? TW'(1)
                             : ((hist[i-1] >= TW'(T_FAW)) ? TW'(T_FAW) : hist[i-1] + TW'(1));
                else if (hist[i] < TW'(T_FAW))
                    hist[i] <= hist[i] + TW'(1);
            end
        end
    end

    AST_GUIDE_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(guide_sel)); // R4
    AST_CMD_ON_GUIDE: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> guide_sel == want); // R4
    AST_GUIDE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (guide_sel == g_prev) && (int'(stab) >= SETTLE - 1)); // R5
    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n) is_act |-> since >= TW'(T_RRD)); // R6
    AST_ACT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> hist[ACT_WINDOW-1] >= TW'(T_FAW)); // R7
    AST_WR_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> cmd_valid && cmd_op == 2'(OP_WR)); // R8
    AST_WR_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'(OP_WR)) |-> $past(is_act)); // R8
    AST_RSP_POWERED: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> guide_sel != '0); // R9
    AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !cmd_valid); // R10
endmodule

bind pgc_sched pgc_sched_chk #(
    .NUM_CHIPS(NUM_CHIPS), .T_RRD(T_RRD), .T_FAW(T_FAW), .SETTLE(SETTLE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_chip(cmd_chip), .guide_sel(guide_sel), .wr_valid(wr_valid), .rsp_valid(rsp_valid)
);

// File: tb/sim_pgc_sched.sv
module sim_pgc_sched;
    localparam int NC = 2, BPC = 4, TGW = 4, LW = 512;
    localparam int RRD = 3, FAW = 16, RL = 4, ST = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [0:0] req_chip = '0;
    logic [1:0] req_bank = '0;
    logic [TGW-1:0] req_tag = '0;
    logic [LW-1:0] req_wdata = '0, mem_rdata = '0;
    logic req_ready, cmd_valid, wr_valid, rsp_valid;
    logic [1:0] cmd_op, cmd_bank;
    logic [0:0] cmd_chip;
    logic [NC-1:0] guide_sel;
    logic [LW-1:0] wr_data, rsp_data;
    logic [TGW-1:0] rsp_tag;

    pgc_sched u0 (.*);

    always #5 clk = ~clk;

    int cyc = 0, n_chk = 0, n_fail = 0, done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int act_t[64], act_b[64], wr_t[64], rsp_t[64], rsp_g[64];
    int n_act = 0, n_wr = 0, n_rsp = 0, rd_chip = 0;
    logic [LW-1:0] rsp_d[64];
    logic [LW-1:0] exp_data[8];
    logic [LW-1:0] mem[8];

    function automatic logic [LW-1:0] mkdata(input int n);
        logic [31:0] w;
        w = 32'(n) * 32'h9E37_79B1 ^ 32'h5A5A_0000;
        return {16{w}};
    endfunction

    task automatic chk(input bit ok, input string r, input longint a, input longint e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", r, a, e);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        if (rsp_valid) begin
            rsp_t[n_rsp] = cyc; rsp_g[n_rsp] = int'(rsp_tag); rsp_d[n_rsp] = rsp_data; n_rsp++;
            chk(guide_sel == NC'(1 << rd_chip), "R9 guide at response", guide_sel, 1 << rd_chip);
        end
        if (cmd_valid) begin
            chk(guide_sel == NC'(1 << cmd_chip), "R4 guide at command", guide_sel, 1 << cmd_chip);
            case (cmd_op)
                2'd1: begin act_t[n_act] = cyc; act_b[n_act] = {cmd_chip, cmd_bank}; n_act++; end
                2'd3: begin
                    wr_t[n_wr] = cyc; n_wr++;
                    chk(wr_valid && wr_data == exp_data[{cmd_chip, cmd_bank}], "R8 write beat",
                        wr_data[31:0], exp_data[{cmd_chip, cmd_bank}][31:0]);
                    mem[{cmd_chip, cmd_bank}] = wr_data;
                end
                2'd2: begin mem_rdata = mem[{cmd_chip, cmd_bank}]; rd_chip = int'(cmd_chip); end
                default: ;
            endcase
        end
    end

    task automatic send(input bit w, input int flat, input int tag, output int acc);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_chip = flat[2]; req_bank = flat[1:0];
        req_tag = TGW'(tag); req_wdata = mkdata(flat);
        if (w) exp_data[flat] = mkdata(flat);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        acc = cyc;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 10);
        if (done == 0) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        int k, b, r0, r1;
        for (int i = 0; i < 8; i++) begin exp_data[i] = mkdata(i); mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(guide_sel == '0, "R1 guide", guide_sel, 0);
        chk(!cmd_valid && !rsp_valid, "R1 no cmd/rsp", cmd_valid, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);

        // single write chip1 bank2 (flat 6): guide switch path
        b = n_act;
        send(1'b1, 6, 3, k);
        idle(20);
        chk(act_t[b] == k + 2 + ST, "R5 act after settle", act_t[b], k + 2 + ST);
        chk(wr_t[n_wr-1] == act_t[b] + 1, "R8 write after act", wr_t[n_wr-1], act_t[b] + 1);
        chk(guide_sel == '0, "R4 dark when idle", guide_sel, 0);

        // single read of flat 6
        b = n_act;
        send(1'b0, 6, 5, k);
        idle(20);
        chk(act_t[b] == k + 2 + ST, "R5 read act", act_t[b], k + 2 + ST);
        chk(rsp_t[n_rsp-1] == act_t[b] + 1 + RL, "R9 latency", rsp_t[n_rsp-1], act_t[b] + 1 + RL);
        chk(rsp_g[n_rsp-1] == 5, "R9 tag", rsp_g[n_rsp-1], 5);
        chk(rsp_d[n_rsp-1] == exp_data[6], "R9 data", rsp_d[n_rsp-1][31:0], exp_data[6][31:0]);

        // activate burst on chip0: spacing and window
        idle(40);
        b = n_act;
        send(1'b1, 0, 0, k);
        send(1'b1, 1, 0, r0);
        send(1'b1, 2, 0, r0);
        send(1'b1, 3, 0, r0);
        send(1'b1, 0, 0, r0);
        idle(60);
        chk(act_t[b] == k + 2 + ST, "R5 burst first act", act_t[b], k + 2 + ST);
        for (int i = 1; i < 4; i++)
            chk(act_t[b+i] - act_t[b+i-1] == RRD, "R6 act spacing", act_t[b+i] - act_t[b+i-1], RRD);
        chk(act_t[b+4] - act_t[b] == FAW, "R7 four-act window", act_t[b+4] - act_t[b], FAW);
        chk(act_b[b+4] == 0, "R3 requeued bank last", act_b[b+4], 0);

        // round-robin: read flat1 keeps sequencer busy while 5,2,7 queue up
        idle(40);
        b = n_act;
        send(1'b0, 1, 1, k);
        send(1'b1, 5, 0, r0);
        send(1'b1, 2, 0, r0);
        send(1'b1, 7, 0, r0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_chip = 1'b1; req_bank = 2'd1; req_wdata = '1;
        #1;
        chk(req_ready == 1'b0, "R2 busy bank not ready", req_ready, 0);
        #2;
        req_valid = 1'b0;
        idle(80);
        chk(n_act - b == 4, "R2 no extra transaction", n_act - b, 4);
        chk(act_b[b] == 1, "R3 order 0", act_b[b], 1);
        chk(act_b[b+1] == 2, "R3 order 1", act_b[b+1], 2);
        chk(act_b[b+2] == 5, "R3 order 2", act_b[b+2], 5);
        chk(act_b[b+3] == 7, "R3 order 3", act_b[b+3], 7);
        chk(rsp_d[n_rsp-1] == exp_data[1], "R9 data bank1", rsp_d[n_rsp-1][31:0], exp_data[1][31:0]);

        // back-to-back reads across chips
        idle(40);
        b = n_act; r1 = n_rsp;
        send(1'b0, 2, 9, k);
        send(1'b0, 6, 10, r0);
        idle(60);
        chk(rsp_g[r1] == 9 && rsp_g[r1+1] == 10, "R10 in-order tags", rsp_g[r1+1], 10);
        chk(rsp_d[r1] == exp_data[2], "R10 first data", rsp_d[r1][31:0], exp_data[2][31:0]);
        chk(rsp_d[r1+1] == exp_data[6], "R10 second data", rsp_d[r1+1][31:0], exp_data[6][31:0]);
        chk(act_t[b+1] == rsp_t[r1] + 2 + ST, "R5 chip switch after read",
            act_t[b+1], rsp_t[r1] + 2 + ST);
        chk(rsp_t[r1+1] - act_t[b+1] == 1 + RL, "R9 second latency", rsp_t[r1+1] - act_t[b+1], 1 + RL);
        chk(guide_sel == '0, "R4 dark at end", guide_sel, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule